// File: doc/BRIEF.md
# Leader-Set Replacement Policy Duel Selector

This block picks, for an entire set-associative cache, which of two replacement policies the non-sampled sets should follow: a cost-weighted linear policy that blends recency with the quantized cost of a miss, or plain LRU. The main tag directory always runs the linear policy. A small shadow tag directory runs LRU, but only for a fixed group of sampled sets, the leaders. On every access the cache reports the set index, whether the main directory hit, whether the shadow LRU directory hit, and the quantized cost of the miss. The block uses these reports to train a single global saturating counter.

Only leader sets move the counter. When the two directories disagree, the counter moves by the miss cost toward the policy that hit. The counter's top bit, held in a register, tells every follower set which policy to use. Leader sets are found from the index alone: a set is a leader when its upper index field equals its lower index field. With the default 1024 sets this gives 32 leaders spread evenly over the set range.

Top module: `policy_duel_sel`

## Requirements
- R1: After reset the counter holds its midpoint (512 for the default 10-bit counter) and `follow_lin_o` is 1.
- R2: An access is a leader access when `set_idx_i[9:5]` equals `set_idx_i[4:0]` (upper 5 bits equal lower 5 bits); every other index is a follower.
- R3: A valid access to a follower set never changes the counter, whatever its hit results and cost.
- R4: A valid leader access where `lin_hit_i` and `lru_hit_i` are equal (both 1 or both 0) leaves the counter unchanged.
- R5: A valid leader access with `lin_hit_i`=1 and `lru_hit_i`=0 adds `cost_i` to the counter.
- R6: A valid leader access with `lin_hit_i`=0 and `lru_hit_i`=1 subtracts `cost_i` from the counter.
- R7: An increment that would pass 1023 leaves the counter at 1023; it does not wrap.
- R8: A decrement that would go below 0 leaves the counter at 0; it does not wrap.
- R9: `follow_lin_o` is 1 (linear policy) while the counter's most significant bit is 1 (counter at least 512) and 0 (LRU) otherwise.
- R10: `follow_lin_o` is registered from the counter: an access sampled at clock edge N updates the counter at edge N and the output at edge N+1.
- R11: When `acc_vld_i` is 0 the other inputs are ignored and the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | Access report valid this cycle |
| set_idx_i | input | 10 | Set index of the access |
| lin_hit_i | input | 1 | Main (linear-policy) directory hit |
| lru_hit_i | input | 1 | Shadow LRU directory hit (meaningful for leader sets) |
| cost_i | input | 3 | Quantized cost of the miss |
| follow_lin_o | output | 1 | Policy for follower sets: 1 linear, 0 LRU |

## Verification
The counter is visible at the ports only through its top bit, so a wrong counter value shows up only when it crosses the 512 threshold. Each scenario therefore starts the counter at a known distance from the threshold, and an error of a single unit flips `follow_lin_o` two edges after the access that caused it. A wrong leader decode or a follower that trains the counter shows up at once when the counter sits at its reset midpoint. A saturation error shows up only later, during the climb back toward the threshold, once the exact number of steps to the flip no longer matches.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic [1:0] {
    OUT_TIE      = 2'd0,
    OUT_LIN_WINS = 2'd1,
    OUT_LRU_WINS = 2'd2
  } duel_out_e;
endpackage

// File: rtl/leader_match.sv
module leader_match #(
  parameter int IDX_W  = 10,
  parameter int LEAD_W = 5
) (
  input  logic [IDX_W-1:0] set_idx_i,
  output logic             leader_o
);
  localparam int HI_LSB = IDX_W - LEAD_W;

  assign leader_o = (set_idx_i[IDX_W-1:HI_LSB] == set_idx_i[LEAD_W-1:0]);
endmodule

// File: rtl/outcome_decode.sv
module outcome_decode
  import sel_pkg::*;
(
  input  logic      vld_i,
  input  logic      leader_i,
  input  logic      lin_hit_i,
  input  logic      lru_hit_i,
  output logic      en_o,
  output logic      up_o
);
  duel_out_e outc;

  always_comb begin
    outc = OUT_TIE;
    if (lin_hit_i && !lru_hit_i)      outc = OUT_LIN_WINS;
    else if (!lin_hit_i && lru_hit_i) outc = OUT_LRU_WINS;
  end

  assign en_o = vld_i && leader_i && (outc != OUT_TIE);
  assign up_o = (outc == OUT_LIN_WINS);
endmodule

// File: rtl/duel_counter.sv
module duel_counter #(
  parameter int CNT_W  = 10,
  parameter int COST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              up_i,
  input  logic [COST_W-1:0] cost_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] COST_MAX = CNT_W'((1 << COST_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cost_ext;
  logic [CNT_W:0]   up_sum;

  assign cost_ext = CNT_W'(cost_i);
  assign up_sum   = {1'b0, cnt_q} + {1'b0, cost_ext};

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (up_i) cnt_d = up_sum[CNT_W] ? CNT_MAX : up_sum[CNT_W-1:0];
      else      cnt_d = (cost_ext > cnt_q) ? '0 : (cnt_q - cost_ext);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_MID;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // Any single step moves the count by at most the largest cost, so the count cannot wrap.
  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q >= $past(cnt_q)) ? (cnt_q - $past(cnt_q)) : ($past(cnt_q) - cnt_q)) <= COST_MAX); // R7 R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/policy_duel_sel.sv
module policy_duel_sel #(
  parameter int IDX_W  = 10,
  parameter int LEAD_W = 5,
  parameter int CNT_W  = 10,
  parameter int COST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_vld_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic              lin_hit_i,
  input  logic              lru_hit_i,
  input  logic [COST_W-1:0] cost_i,
  output logic              follow_lin_o
);
  logic             leader, cnt_en, cnt_up;
  logic [CNT_W-1:0] cnt;
  logic             pol_q;

  leader_match #(.IDX_W(IDX_W), .LEAD_W(LEAD_W)) u_lead (
    .set_idx_i (set_idx_i),
    .leader_o  (leader)
  );

  outcome_decode u_dec (
    .vld_i     (acc_vld_i),
    .leader_i  (leader),
    .lin_hit_i (lin_hit_i),
    .lru_hit_i (lru_hit_i),
    .en_o      (cnt_en),
    .up_o      (cnt_up)
  );

  duel_counter #(.CNT_W(CNT_W), .COST_W(COST_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .up_i   (cnt_up),
    .cost_i (cost_i),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pol_q <= 1'b1;
    else         pol_q <= cnt[CNT_W-1];
  end

  assign follow_lin_o = pol_q;

  AST_FOLLOWER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && !leader) |=> $stable(cnt)); // R3
  AST_TIE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && leader && (lin_hit_i == lru_hit_i)) |=> $stable(cnt)); // R4
  AST_LIN_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && leader && lin_hit_i && !lru_hit_i) |=> (cnt >= $past(cnt))); // R5
  AST_LRU_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && leader && !lin_hit_i && lru_hit_i) |=> (cnt <= $past(cnt))); // R6
  AST_POLICY_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    follow_lin_o == $past(cnt[CNT_W-1])); // R10
endmodule

// File: tb/tb_policy_duel_sel.sv
module tb_policy_duel_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_vld_i = 1'b0;
  logic [9:0] set_idx_i = '0;
  logic       lin_hit_i = 1'b0;
  logic       lru_hit_i = 1'b0;
  logic [2:0] cost_i = '0;
  logic       follow_lin_o;

  int n_chk = 0;
  int n_fail = 0;
  int model = 512;

  always #2 clk_i = ~clk_i;

  policy_duel_sel dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_vld_i(acc_vld_i), .set_idx_i(set_idx_i),
    .lin_hit_i(lin_hit_i), .lru_hit_i(lru_hit_i), .cost_i(cost_i),
    .follow_lin_o(follow_lin_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: follow_lin_o=%0b expected %0b (model count %0d)", req, act, exp, model);
    end
  endtask

  function automatic logic is_leader(input logic [9:0] idx);
    return idx[9:5] == idx[4:0]; // R2
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    acc_vld_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model = 512;
    @(negedge clk_i);
    check(follow_lin_o, 1'b1, "R1");
  endtask

  // One access, model update, check two edges later.
  task automatic acc(input logic vld, input logic [9:0] idx, input logic lh, input logic rh,
                     input logic [2:0] c, input string req);
    acc_vld_i = vld; set_idx_i = idx; lin_hit_i = lh; lru_hit_i = rh; cost_i = c;
    @(negedge clk_i);
    acc_vld_i = 1'b0;
    if (vld && is_leader(idx) && (lh != rh)) begin
      if (lh) model = (model + c > 1023) ? 1023 : model + c;
      else    model = (model < c) ? 0 : model - c;
    end
    @(negedge clk_i);
    check(follow_lin_o, model >= 512, req);
  endtask

  task automatic t_timing();
    do_reset();
    acc_vld_i = 1'b1; set_idx_i = 10'h000; lin_hit_i = 1'b0; lru_hit_i = 1'b1; cost_i = 3'd1;
    @(negedge clk_i);
    acc_vld_i = 1'b0;
    check(follow_lin_o, 1'b1, "R10 one edge");
    @(negedge clk_i);
    model = 511;
    check(follow_lin_o, 1'b0, "R10 two edges");
  endtask

  task automatic t_followers();
    do_reset();
    acc(1'b1, 10'h022, 1'b0, 1'b1, 3'd7, "R3 follower lru-win");
    acc(1'b1, 10'h200, 1'b0, 1'b1, 3'd7, "R3 follower idx 200");
    acc(1'b1, 10'h01f, 1'b0, 1'b1, 3'd7, "R2 R3 follower idx 01f");
    acc(1'b1, 10'h3fe, 1'b0, 1'b1, 3'd7, "R2 R3 follower idx 3fe");
    acc(1'b0, 10'h000, 1'b0, 1'b1, 3'd7, "R11 invalid leader");
    acc(1'b1, 10'h021, 1'b0, 1'b1, 3'd1, "R2 R6 leader idx 021");
    acc(1'b1, 10'h3ff, 1'b1, 1'b0, 3'd1, "R2 R5 leader idx 3ff");
  endtask

  task automatic t_ties();
    do_reset();
    acc(1'b1, 10'h000, 1'b0, 1'b0, 3'd7, "R4 both miss");
    acc(1'b1, 10'h063, 1'b1, 1'b1, 3'd7, "R4 both hit");
    acc(1'b1, 10'h063, 1'b0, 1'b1, 3'd0, "R6 zero cost");
    acc(1'b1, 10'h063, 1'b0, 1'b1, 3'd3, "R6 R9 drop below mid");
    acc(1'b1, 10'h0a5, 1'b1, 1'b0, 3'd2, "R5 R9 still below");
    acc(1'b1, 10'h0a5, 1'b1, 1'b0, 3'd1, "R5 R9 back to mid");
  endtask

  task automatic t_sat_high();
    do_reset();
    for (int i = 0; i < 100; i++) acc(1'b1, 10'h2b5, 1'b1, 1'b0, 3'd7, "R5 R7 climb");
    for (int i = 0; i < 73; i++) acc(1'b1, 10'h2b5, 1'b0, 1'b1, 3'd7, "R6 R7 descend");
    check(follow_lin_o, 1'b1, "R7 at 512 after saturating high");
    acc(1'b1, 10'h2b5, 1'b0, 1'b1, 3'd1, "R7 R9 crosses to 511");
  endtask

  task automatic t_sat_low();
    do_reset();
    for (int i = 0; i < 100; i++) acc(1'b1, 10'h18c, 1'b0, 1'b1, 3'd7, "R6 R8 descend");
    for (int i = 0; i < 73; i++) acc(1'b1, 10'h18c, 1'b1, 1'b0, 3'd7, "R5 R8 climb");
    check(follow_lin_o, 1'b0, "R8 at 511 after saturating low");
    acc(1'b1, 10'h18c, 1'b1, 1'b0, 3'd1, "R8 R9 crosses to 512");
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_timing();
    t_followers();
    t_ties();
    t_sat_high();
    t_sat_low();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule